// File: doc/BRIEF.md
# Per-channel output-enable serializer

This block tells external stream drivers, one time slot at a time, whether to drive a channel or to leave it high-impedance. It stores one enable bit for each of 512 channels on each of 16 output streams. It shifts these bits out on four serial control lines, one bit per tick of a control-clock enable that runs at half the stream bit rate. Each control line serves four streams. Line k carries streams k, k+4, k+8 and k+12. The bits are interleaved channel-major: for each channel, the line sends that channel's bit for each of its four streams, lowest stream first, before it moves to the next channel.

The readout is locked to a frame pulse. A frame holds 2048 control periods on every line. The block launches the first bit of a frame ten periods ahead of the frame boundary, so that the drivers have the enable in hand before their slot arrives. Software or a neighbouring block loads the enable bits through a one-cycle write port. Stream addresses 16 to 31 stand for the upper streams, which are unused at the highest stream rate. A write to one of those addresses is discarded.

Top module: `oe_ctl_serializer`

## Requirements
- R1: There are four control lines, `ctl_out[3:0]`. Line k carries only the enable bits of streams k, k+4, k+8 and k+12. Stream k+4·s occupies slot s of line k.
- R2: Control periods are numbered p = 0..2047, zero-based. Period 0 is the one that starts at the tick on which `frame_pulse` is high. In period p, every line presents channel c, slot s, where p = (4·c + s − 10) mod 2048.
- R3: The following positions hold. Stream 0 channel 0 goes out on line 0 at p = 2038. Stream 12 channel 0 goes out on line 0 at p = 2041. Stream 4 channel 511 goes out on line 0 at p = 2035. Stream 5 channel 5 goes out on line 1 at p = 11.
- R4: Each transmitted bit equals the stored enable bit of its stream and channel. 1 means the channel is driven. 0 means it is high-impedance.
- R5: `ctl_out` changes only on a clock edge where `tick` is high. It is registered and holds its value between ticks.
- R6: A tick with `frame_pulse` high restarts the readout at p = 0. A tick without the pulse advances p by one, and p wraps from 2047 to 0. The readout free-runs from p = 0 after reset.
- R7: A write with `wr_stream` in 16..31 has no effect on any stored bit or on any output.
- R8: Reset clears every enable bit, so `ctl_out` stays 0 until a bit is written to 1.
- R9: Suppose a write lands on the same edge as the tick that reads the same bit. The output for that period then shows the old value, and the new value appears from the next readout of that bit.
- R10: A write with `we` high and `wr_stream` < 16 sets bit (`wr_stream`, `wr_chan`) to `wr_bit` on that clock edge and changes no other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Control-period enable, one per control-clock period |
| frame_pulse | input | 1 | Frame boundary marker, sampled with `tick` |
| we | input | 1 | Write strobe for the enable store |
| wr_stream | input | 5 | Stream address; 16..31 are discarded |
| wr_chan | input | 9 | Channel address |
| wr_bit | input | 1 | Enable value to store |
| ctl_out | output | 4 | Serial control lines, one bit per control period |

## Verification
The write port and the serial readout share one storage word, so they can meet on the same clock edge. The bench provokes this by issuing, on the exact tick that reads stream 5 channel 5 at p = 11, a write that inverts that bit. The output for that period must still show the old value. The following frame must show the new value at the same period. Every other period is swept in full frames against an arithmetic model of the interleave and the advance.

// File: rtl/oe_ctl_serializer.sv
module oe_ctl_serializer #(
  parameter int LINES     = 4,
  parameter int SLOTS     = 4,
  parameter int CHANNELS  = 512,
  parameter int ADVANCE   = 10,
  parameter int STREAM_AW = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         frame_pulse,
  input  logic                         we,
  input  logic [STREAM_AW-1:0]         wr_stream,
  input  logic [$clog2(CHANNELS)-1:0]  wr_chan,
  input  logic                         wr_bit,
  output logic [LINES-1:0]             ctl_out
);

  localparam int STREAMS = LINES * SLOTS;
  localparam int FRAME   = CHANNELS * SLOTS;
  localparam int CNT_W   = $clog2(FRAME);
  localparam int CH_W    = $clog2(CHANNELS);
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int SIDX_W  = $clog2(STREAMS);

  logic [STREAMS-1:0] en_mem [CHANNELS];
  logic [CNT_W-1:0]   pos, cur, rd_idx;
  logic [CH_W-1:0]    rd_ch;
  logic [SLOT_W-1:0]  rd_slot;
  logic [STREAMS-1:0] rd_word;
  logic [SLOTS-1:0]   line_bits [LINES];
  logic [LINES-1:0]   nxt;
  logic               wr_ok;

  assign wr_ok   = we && (int'(wr_stream) < STREAMS);
  assign cur     = frame_pulse ? '0 : pos;
  assign rd_idx  = cur + CNT_W'(ADVANCE);
  assign rd_ch   = rd_idx[CNT_W-1:SLOT_W];
  assign rd_slot = rd_idx[SLOT_W-1:0];
  assign rd_word = en_mem[rd_ch];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < CHANNELS; c++) en_mem[c] <= '0;
    end else if (wr_ok) begin
      en_mem[wr_chan][wr_stream[SIDX_W-1:0]] <= wr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (tick) pos <= cur + CNT_W'(1);
  end

  for (genvar k = 0; k < LINES; k++) begin : g_line
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign line_bits[k][s] = rd_word[k + LINES * s];
    end
    assign nxt[k] = line_bits[k][rd_slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctl_out <= '0;
    else if (tick) ctl_out <= nxt;
  end

  logic dirty;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dirty <= 1'b0;
    else if (wr_ok) dirty <= 1'b1;
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ctl_out));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frame_pulse) |=> (pos == CNT_W'(1)));

  assert_freerun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !frame_pulse) |=> (pos == CNT_W'($past(pos) + CNT_W'(1))));

  assert_upper_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(wr_stream) >= STREAMS) |=> (en_mem[$past(wr_chan)] == $past(en_mem[wr_chan])));

  assert_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dirty |-> (ctl_out == '0));

endmodule

// File: tb/oe_ctl_serializer_bench.sv
module oe_ctl_serializer_bench;
  logic       clk = 0, rst_n = 0, tick = 0, frame_pulse = 0, we = 0, wr_bit = 0;
  logic [4:0] wr_stream = 0;
  logic [8:0] wr_chan = 0;
  logic [3:0] ctl_out;

  int checks = 0, fails = 0, cyc = 0, bpos = 0;
  bit model [16][512];
  logic [3:0] got [2048];

  oe_ctl_serializer u_oe_ctl_serializer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .frame_pulse(frame_pulse), .we(we),
    .wr_stream(wr_stream), .wr_chan(wr_chan), .wr_bit(wr_bit), .ctl_out(ctl_out));

  always #10 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_vec(input int p);
    int a = (p + 10) % 2048;
    int c = a / 4;
    int s = a % 4;
    logic [3:0] v;
    for (int k = 0; k < 4; k++) v[k] = model[k + 4 * s][c];
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int s = 0; s < 16; s++) for (int c = 0; c < 512; c++) model[s][c] = 0;
    bpos = 0;
  endtask

  task automatic wr(input int s, input int c, input bit b);
    we = 1; wr_stream = 5'(s); wr_chan = 9'(c); wr_bit = b;
    @(negedge clk); we = 0;
    if (s < 16) model[s][c] = b;
  endtask

  task automatic tick_once(input bit fp, input string tag, input bit cw,
                           input int cs, input int cc, input bit cb);
    int p = fp ? 0 : bpos;
    logic [3:0] e = exp_vec(p);
    logic [3:0] o1;
    tick = 1; frame_pulse = fp;
    if (cw) begin we = 1; wr_stream = 5'(cs); wr_chan = 9'(cc); wr_bit = cb; end
    @(negedge clk);
    tick = 0; frame_pulse = 0; we = 0;
    o1 = ctl_out;
    got[p] = o1;
    chk(tag, o1, e);
    @(negedge clk);
    chk("R5 hold between ticks", ctl_out, o1);
    if (cw && cs < 16) model[cs][cc] = cb;
    bpos = (p + 1) % 2048;
  endtask

  task automatic run_frame(input bit fp, input string tag, input int cp,
                           input int cs, input int cc, input bit cb);
    for (int i = 0; i < 2048; i++)
      tick_once(fp && i == 0, tag, i == cp, cs, cc, cb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset state", ctl_out, 4'b0000);
    run_frame(0, "R8 R6 cleared free-run frame", -1, 0, 0, 0);

    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 512; c++)
        wr(s, c, bit'(((s * 7 + c * 3) ^ (c >> 2)) & 1));
    for (int s = 16; s < 32; s++)
      for (int c = 0; c < 512; c += 3) wr(s, c, 1);
    for (int i = 0; i < 100; i++) tick_once(0, "R1 R2 R4 pre-pulse", 0, 0, 0, 0);
    run_frame(1, "R1 R2 R4 R7 R6 pattern frame", -1, 0, 0, 0);
    run_frame(0, "R6 R1 R2 free-run wrap", -1, 0, 0, 0);

    do_reset();
    chk("R8 reset after pattern", ctl_out, 4'b0000);
    wr(0, 0, 1); wr(12, 0, 1); wr(4, 511, 1); wr(5, 5, 1);
    run_frame(1, "R10 R2 sparse frame", -1, 0, 0, 0);
    chk("R3 stream0 ch0 p2038", got[2038], 4'b0001);
    chk("R3 stream12 ch0 p2041", got[2041], 4'b0001);
    chk("R3 stream4 ch511 p2035", got[2035], 4'b0001);
    chk("R3 stream5 ch5 p11", got[11], 4'b0010);
    begin
      int nz = 0;
      for (int p = 0; p < 2048; p++) if (got[p] != 0) nz++;
      chk("R10 only four set periods", 4'(nz), 4'd4);
    end
    run_frame(1, "R9 collision frame", 11, 5, 5, 0);
    chk("R9 old value on colliding tick", got[11], 4'b0010);
    run_frame(1, "R9 next frame", -1, 0, 0, 0);
    chk("R9 new value next frame", got[11], 4'b0000);
    summary();
  end
endmodule